// File: doc/BRIEF.md
# Serial Program/Verify Target Port

This block is the target side of a two-wire serial port that programs and verifies a small 14-bit program memory. An external programmer toggles a serial clock and drives a data line. The block samples both through synchronizers on its own system clock, so every serial edge is seen a few system cycles late. Each command is six bits long. Three of the commands are followed by a 16-cycle data frame, which the block either receives or sends back on a separate output with its own enable.

The block holds an address counter. The counter covers the user array and an eight-word configuration space based at 0x2000. Word 7 of the configuration space is the configuration word, and its top two bits select code protection. A program pulse request stays high from an accepted begin-programming command until an end-programming command arrives. The write itself is applied when begin programming is accepted. Protected user words read back as zero and ignore writes. The highest user word, the ID words and the configuration word stay accessible at all times.

Top module: `serial_prog_target`

## Requirements
- R1: A command is six serial clock cycles. Each bit is captured on the falling edge, least significant bit first, and the command is decoded after the sixth falling edge. The codes are: 000000 load configuration, 000010 load data, 000100 read, 000110 increment address, 001000 begin programming, 001110 end programming.
- R2: A load frame is 16 serial cycles. Data bits 0..13 are captured on falling edges 2..15. The word becomes the pending load word after the 16th falling edge.
- R3: During a read frame, data bits 0..13 of the addressed word are driven on rising edges 2..15. The output enable goes high at rising edge 2 and low at rising edge 16. It is low at all other times.
- R4: Only the load configuration, load data and read commands take a data frame. Increment, begin, end and any unknown code are followed directly by the next command. An unknown code changes nothing.
- R5: Load configuration sets the address to 0x2000. Increments inside the configuration space stay there and step through its eight words modulo 8. Only a mode reset returns the address to user memory.
- R6: Increment address adds one to the address counter.
- R7: Begin programming is accepted only if a load frame has completed since the last accepted begin. On acceptance it writes the pending word to the current address and raises the program pulse. The pulse stays high until end programming.
- R8: Bits 13:12 of configuration word 7 (address 0x2007) select protection: 11 none, 10 the upper half of user memory, 01 the upper three quarters, 00 all of it. A protected word reads as zero and ignores writes.
- R9: The highest user address, ID words 0x2000..0x2003 and the configuration word always read and write normally.
- R10: A low mode reset clears the address to 0, aborts any frame, drops the output enable and the program pulse, and leaves memory intact.
- R11: After system reset every memory word reads 0x3FFF, and the output enable and program pulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset; erases memory |
| mode_rst_ni | input | 1 | Synchronous active-low programming-mode reset |
| sclk_i | input | 1 | Serial clock from the programmer |
| sdata_i | input | 1 | Serial data from the programmer |
| sdata_o | output | 1 | Serial read data |
| sdata_oe_o | output | 1 | Drive enable for sdata_o |
| prog_pulse_o | output | 1 | Program pulse request |

## Verification
The bench builds the block with a 4-bit user address, which gives 16 user words. With that size every user address can be written and read back. The half and quarter protection boundaries fall at words 8 and 4, and the always-open top word is 15. Each of the four protection codes is applied in turn. Under each code, every user word is read, written and read again, and the bench compares the results with a model computed arithmetically from the protection rule.

// File: rtl/spt_pkg.sv
package spt_pkg;
  localparam int WORD_W = 14;
  localparam int CMD_W  = 6;
  localparam int ADDR_W = 14;
  localparam int CFG_N  = 8;
  localparam int CFG_CP_IDX = 7;

  localparam logic [CMD_W-1:0] CMD_LOAD_CFG  = 6'b000000;
  localparam logic [CMD_W-1:0] CMD_LOAD_DATA = 6'b000010;
  localparam logic [CMD_W-1:0] CMD_READ      = 6'b000100;
  localparam logic [CMD_W-1:0] CMD_INC       = 6'b000110;
  localparam logic [CMD_W-1:0] CMD_BEGIN     = 6'b001000;
  localparam logic [CMD_W-1:0] CMD_END       = 6'b001110;

  localparam logic [ADDR_W-1:0] CFG_BASE = 14'h2000;

  typedef enum logic {ST_CMD, ST_DATA} frame_st_e;

  function automatic logic has_frame(input logic [CMD_W-1:0] c);
    return (c == CMD_LOAD_CFG) || (c == CMD_LOAD_DATA) || (c == CMD_READ);
  endfunction
endpackage

// File: rtl/spt_sync.sv
module spt_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/spt_frame.sv
module spt_frame
  import spt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic              cmd_valid_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              load_done_o,
  output logic [WORD_W-1:0] load_word_o,
  output logic              sdata_o,
  output logic              sdata_oe_o
);
  localparam int FRAME_LEN = WORD_W + 2;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int IDX_W     = $clog2(WORD_W);
  localparam int CBIT_W    = $clog2(CMD_W);

  frame_st_e         st_q;
  logic              sclk_q, rd_kind_q, cmd_valid_q, load_done_q, oe_q, dout_q;
  logic [CBIT_W-1:0] bit_cnt_q;
  logic [CNT_W-1:0]  rcnt_q, fcnt_q, rk, fk, ridx, fidx;
  logic [CMD_W-1:0]  cmd_sh_q, cmd_next;
  logic [WORD_W-1:0] rd_q, ld_sh_q;
  logic              rise, fall;

  assign rise     = sclk_i & ~sclk_q;
  assign fall     = ~sclk_i & sclk_q;
  assign cmd_next = {sdata_i, cmd_sh_q[CMD_W-1:1]};
  assign rk       = rcnt_q + 1'b1;
  assign fk       = fcnt_q + 1'b1;
  assign ridx     = rk - CNT_W'(2);
  assign fidx     = fk - CNT_W'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_CMD; sclk_q <= 1'b0; rd_kind_q <= 1'b0;
      cmd_valid_q <= 1'b0; load_done_q <= 1'b0; oe_q <= 1'b0; dout_q <= 1'b0;
      bit_cnt_q <= '0; rcnt_q <= '0; fcnt_q <= '0;
      cmd_sh_q <= '0; rd_q <= '0; ld_sh_q <= '0;
    end else begin
      sclk_q      <= sclk_i;
      cmd_valid_q <= 1'b0;
      load_done_q <= 1'b0;
      if (!mode_rst_ni) begin
        st_q <= ST_CMD; bit_cnt_q <= '0; rcnt_q <= '0; fcnt_q <= '0;
        oe_q <= 1'b0; dout_q <= 1'b0;
      end else if (st_q == ST_CMD) begin
        if (fall) begin
          cmd_sh_q <= cmd_next;
          if (bit_cnt_q == CBIT_W'(CMD_W - 1)) begin
            bit_cnt_q   <= '0;
            cmd_valid_q <= 1'b1;
            if (has_frame(cmd_next)) begin
              st_q      <= ST_DATA;
              rd_kind_q <= (cmd_next == CMD_READ);
              rcnt_q    <= '0;
              fcnt_q    <= '0;
              rd_q      <= rd_word_i;
            end
          end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
      end else begin
        if (rise) begin
          rcnt_q <= rk;
          if (rd_kind_q && rk >= CNT_W'(2) && rk <= CNT_W'(FRAME_LEN - 1)) begin
            oe_q   <= 1'b1;
            dout_q <= rd_q[ridx[IDX_W-1:0]];
          end else begin
            oe_q <= 1'b0;
          end
        end
        if (fall) begin
          fcnt_q <= fk;
          if (!rd_kind_q && fk >= CNT_W'(2) && fk <= CNT_W'(FRAME_LEN - 1))
            ld_sh_q[fidx[IDX_W-1:0]] <= sdata_i;
          if (fk == CNT_W'(FRAME_LEN)) begin
            st_q        <= ST_CMD;
            oe_q        <= 1'b0;
            load_done_q <= !rd_kind_q;
          end
        end
      end
    end
  end

  assign cmd_valid_o = cmd_valid_q;
  assign cmd_o       = cmd_sh_q;
  assign load_done_o = load_done_q;
  assign load_word_o = ld_sh_q;
  assign sdata_o     = dout_q;
  assign sdata_oe_o  = oe_q;

  p_oe_read_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdata_oe_o |-> (st_q == ST_DATA && rd_kind_q));
  p_cmd_on_fall_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_q |-> $past(fall));
  p_load_kind_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_done_q |-> !rd_kind_q);
  p_oe_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_rst_ni |=> !sdata_oe_o);
endmodule

// File: rtl/spt_store.sv
module spt_store
  import spt_pkg::*;
#(
  parameter int USER_AW = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_rst_ni,
  input  logic              cmd_valid_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              load_done_i,
  input  logic [WORD_W-1:0] load_word_i,
  output logic [WORD_W-1:0] rd_word_o,
  output logic              prog_pulse_o
);
  localparam int DEPTH = 1 << USER_AW;
  localparam int HALF  = DEPTH / 2;
  localparam int QUART = DEPTH / 4;
  localparam int CFG_AW = $clog2(CFG_N);

  logic [WORD_W-1:0] user_mem [DEPTH];
  logic [WORD_W-1:0] cfg_mem  [CFG_N];
  logic [ADDR_W-1:0] addr_q, addr_inc;
  logic [WORD_W-1:0] load_buf_q;
  logic              load_valid_q, prog_q, in_cfg, prot, begin_ok;
  logic [USER_AW-1:0] uidx;
  logic [CFG_AW-1:0]  cidx;
  logic [1:0]         cp;

  assign in_cfg   = addr_q[ADDR_W-1];
  assign uidx     = addr_q[USER_AW-1:0];
  assign cidx     = addr_q[CFG_AW-1:0];
  assign cp       = cfg_mem[CFG_CP_IDX][WORD_W-1 -: 2];
  assign begin_ok = cmd_valid_i && cmd_i == CMD_BEGIN && load_valid_q;
  assign addr_inc = in_cfg ? {1'b1, addr_q[ADDR_W-2:0] + 1'b1} : addr_q + 1'b1;

  always_comb begin
    unique case (cp)
      2'b11:   prot = 1'b0;
      2'b10:   prot = uidx >= USER_AW'(HALF);
      2'b01:   prot = uidx >= USER_AW'(QUART);
      default: prot = 1'b1;
    endcase
    if (uidx == USER_AW'(DEPTH - 1) || in_cfg) prot = 1'b0;
  end

  assign rd_word_o = in_cfg ? cfg_mem[cidx] : (prot ? '0 : user_mem[uidx]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0; load_buf_q <= '0; load_valid_q <= 1'b0; prog_q <= 1'b0;
    end else if (!mode_rst_ni) begin
      addr_q <= '0; load_valid_q <= 1'b0; prog_q <= 1'b0;
    end else begin
      if (load_done_i) begin
        load_buf_q   <= load_word_i;
        load_valid_q <= 1'b1;
      end
      if (cmd_valid_i) begin
        case (cmd_i)
          CMD_LOAD_CFG: addr_q <= CFG_BASE;
          CMD_INC:      addr_q <= addr_inc;
          CMD_BEGIN: if (load_valid_q) begin
            prog_q       <= 1'b1;
            load_valid_q <= 1'b0;
          end
          CMD_END:      prog_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  // Erased EPROM reads all ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) user_mem[i] <= '1;
      for (int i = 0; i < CFG_N; i++) cfg_mem[i] <= '1;
    end else if (mode_rst_ni && begin_ok && !prot) begin
      if (in_cfg) cfg_mem[cidx]  <= load_buf_q;
      else        user_mem[uidx] <= load_buf_q;
    end
  end

  assign prog_pulse_o = prog_q;

  p_cfg_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_q[ADDR_W-1] && mode_rst_ni) |=> addr_q[ADDR_W-1]);
  p_inc_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == CMD_INC && mode_rst_ni && !addr_q[ADDR_W-1])
      |=> addr_q == $past(addr_q) + 1'b1);
  p_prog_needs_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_pulse_o) |-> $past(load_valid_q));
  p_end_stops_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == CMD_END) |=> !prog_pulse_o);
endmodule

// File: rtl/serial_prog_target.sv
module serial_prog_target
  import spt_pkg::*;
#(
  parameter int USER_AW     = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_rst_ni,
  input  logic sclk_i,
  input  logic sdata_i,
  output logic sdata_o,
  output logic sdata_oe_o,
  output logic prog_pulse_o
);
  logic [1:0]        pins_s;
  logic              cmd_valid, load_done;
  logic [CMD_W-1:0]  cmd;
  logic [WORD_W-1:0] rd_word, load_word;

  spt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, sdata_i}),
    .q_o   (pins_s)
  );

  spt_frame u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_rst_ni(mode_rst_ni),
    .sclk_i     (pins_s[1]),
    .sdata_i    (pins_s[0]),
    .rd_word_i  (rd_word),
    .cmd_valid_o(cmd_valid),
    .cmd_o      (cmd),
    .load_done_o(load_done),
    .load_word_o(load_word),
    .sdata_o    (sdata_o),
    .sdata_oe_o (sdata_oe_o)
  );

  spt_store #(.USER_AW(USER_AW)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_rst_ni (mode_rst_ni),
    .cmd_valid_i (cmd_valid),
    .cmd_i       (cmd),
    .load_done_i (load_done),
    .load_word_i (load_word),
    .rd_word_o   (rd_word),
    .prog_pulse_o(prog_pulse_o)
  );
endmodule

// File: tb/tb_serial_prog_target.sv
module tb_serial_prog_target;
  localparam int CLK_PERIOD = 10;
  localparam int UAW = 4;
  localparam int NW  = 1 << UAW;
  localparam int H   = 6;
  localparam int GAP = 3;

  logic clk = 1'b0, rst_ni = 1'b0, mode_rst_ni = 1'b1, sclk_i = 1'b0, sdata_i = 1'b0;
  logic sdata_o, sdata_oe_o, prog_pulse_o;
  int n_chk = 0, n_fail = 0;
  logic [13:0] model [NW];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_prog_target #(.USER_AW(UAW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_rst_ni(mode_rst_ni),
    .sclk_i(sclk_i), .sdata_i(sdata_i),
    .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o), .prog_pulse_o(prog_pulse_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [13:0] act, input logic [13:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic d);
    sdata_i = d; sclk_i = 1'b1; tick(H);
    sclk_i = 1'b0; tick(H);
  endtask

  task automatic send_cmd(input logic [5:0] c);
    for (int i = 0; i < 6; i++) cyc(c[i]);
    tick(GAP);
  endtask

  task automatic load_frame(input logic [13:0] w);
    cyc(1'b0);
    for (int i = 0; i < 14; i++) cyc(w[i]);
    cyc(1'b0);
    tick(GAP);
  endtask

  task automatic do_read(input string req, input logic [13:0] exp);
    logic [13:0] w;
    logic oe_bad;
    w = '0; oe_bad = 1'b0;
    send_cmd(6'b000100);
    for (int k = 1; k <= 16; k++) begin
      sdata_i = 1'b0; sclk_i = 1'b1; tick(4);
      if (k >= 2 && k <= 15) begin
        w[k-2] = sdata_o;
        if (sdata_oe_o !== 1'b1) oe_bad = 1'b1;
      end else if (sdata_oe_o !== 1'b0) oe_bad = 1'b1;
      tick(H - 4); sclk_i = 1'b0; tick(H);
    end
    tick(GAP);
    chk(req, w, exp);
    chk("R3 output enable window", {13'b0, oe_bad}, 14'd0);
  endtask

  // R7: load data, begin, end with pulse checks
  task automatic prog_word(input logic [13:0] w);
    send_cmd(6'b000010); load_frame(w);
    send_cmd(6'b001000);
    chk("R7 pulse after begin", {13'b0, prog_pulse_o}, 14'd1);
    send_cmd(6'b001110);
    chk("R7 pulse after end", {13'b0, prog_pulse_o}, 14'd0);
  endtask

  task automatic mode_reset();
    mode_rst_ni = 1'b0; tick(3); mode_rst_ni = 1'b1; tick(2);
  endtask

  function automatic bit is_prot(input int a, input int cp);
    if (a == NW - 1) return 1'b0;
    case (cp)
      3: return 1'b0;
      2: return a >= NW / 2;
      1: return a >= NW / 4;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [13:0] pat(input int a);
    return 14'((a * 14'h123) ^ 14'h2A5);
  endfunction

  task automatic write_cfg(input int cp);
    logic [13:0] idv, cfgw;
    idv  = 14'h0AB ^ 14'(cp);
    cfgw = {2'(cp), 12'hF5A};
    mode_reset();
    send_cmd(6'b000000); load_frame(idv);
    send_cmd(6'b001000); send_cmd(6'b001110);
    do_read("R5 R9 ID word at 0x2000", idv);
    for (int i = 0; i < 7; i++) send_cmd(6'b000110);
    prog_word(cfgw);
    do_read("R9 config word readback", cfgw);
    send_cmd(6'b000110);
    do_read("R5 config space wraps to ID word", idv);
    mode_reset();
  endtask

  initial begin
    tick(4); rst_ni = 1'b1; tick(4);
    chk("R11 oe after reset", {13'b0, sdata_oe_o}, 14'd0);
    chk("R11 pulse after reset", {13'b0, prog_pulse_o}, 14'd0);
    do_read("R11 erased word", 14'h3FFF);

    // R2 R6: write and read back every user word
    mode_reset();
    for (int a = 0; a < NW; a++) begin
      prog_word(pat(a));
      model[a] = pat(a);
      if (a == 3) begin
        send_cmd(6'b001000);
        chk("R7 begin without load ignored", {13'b0, prog_pulse_o}, 14'd0);
      end
      if (a == 5) send_cmd(6'b010101); // R4 unknown code, no frame
      do_read("R2 R6 readback", model[a]);
      send_cmd(6'b000110);
    end

    // R8 R9: each protection code over all user words
    for (int cp = 3; cp >= 0; cp--) begin
      write_cfg(cp);
      for (int a = 0; a < NW; a++) begin
        logic [13:0] v;
        v = 14'((a << 4) | cp) ^ 14'h1555;
        do_read("R8 masked read", is_prot(a, cp) ? 14'h0 : model[a]);
        prog_word(v);
        if (!is_prot(a, cp)) model[a] = v;
        do_read("R8 R9 write then read", is_prot(a, cp) ? 14'h0 : model[a]);
        send_cmd(6'b000110);
      end
    end

    // R10: mode reset during a read frame
    write_cfg(3);
    send_cmd(6'b000110);
    send_cmd(6'b000100);
    for (int k = 1; k <= 3; k++) cyc(1'b0);
    sclk_i = 1'b1; tick(H); sclk_i = 1'b0; tick(2);
    chk("R10 oe active before reset", {13'b0, sdata_oe_o}, 14'd1);
    mode_reset();
    chk("R10 oe released", {13'b0, sdata_oe_o}, 14'd0);
    tick(H);
    do_read("R10 address back to 0", model[0]);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule